// File: doc/BRIEF.md
# Pixel Hit Timestamp Recorder

This block is the digital back end of a single detector pixel. A shared timestamp bus is distributed to every pixel. Whenever the pixel's already synchronised discriminator output makes a rising transition while a bunch train is being recorded, the current bus value is captured into the next free slot of a tiny local store. A write pointer selects that slot. When every slot is taken, later hits in the same train are discarded and a sticky overflow flag records the loss.

Between trains the surrounding readout logic strobes the pixel. Each strobe returns one stored timestamp, oldest first, with a valid flag and a flag marking the final entry. A pixel with nothing left to deliver raises its empty indication, so an array-level multiplexer can skip it at once. A storage power-enable output lets the slots be switched off in two cases: when the train ends and the pixel recorded no hits, or when its last entry has been read. A train-start pulse opens the next train and switches the storage back on.

Top module: `pixstamp_recorder`

## Requirements
- R1: While and right after reset, `empty_o` is 1 and `overflow_o`, `mem_pwr_en`, `rd_valid` and `rd_last` are 0.
- R2: A `train_start` pulse empties the pixel, clears overflow, clears `rd_valid` and sets `mem_pwr_en`, all visible one cycle later. It takes priority over a hit or a read strobe in the same cycle, and both of those are dropped.
- R3: A hit is a cycle in which `fire_in` is 1, was 0 in the previous cycle, `rec_en` is 1 and storage power is on. A hit captures the `ts_bus` value present in that same cycle. A level held high records only one hit.
- R4: Hits fill the slots in arrival order, with slot index 0 first. The number of filled slots never exceeds DEPTH, and reads return the stored values in the order they were captured.
- R5: A hit that arrives with all DEPTH slots filled is discarded and sets `overflow_o` one cycle later. `overflow_o` stays set until the next `train_start`.
- R6: `empty_o` is 1 exactly when no captured timestamp remains unread.
- R7: A `rd_req` sampled with `rec_en` at 0 and an unread entry present gives, one cycle later, `rd_valid` = 1 and `rd_data` set to the oldest unread timestamp. In that same cycle `rd_last` is 1 when that entry was the final unread one. A `rd_req` with no unread entry gives `rd_valid` = 0.
- R8: A `rd_req` sampled while `rec_en` is 1 is ignored: `rd_valid` stays 0 and no entry is consumed.
- R9: When `rec_en` is 0 and no unread entry remains, `mem_pwr_en` falls at the following clock edge. An empty pixel therefore powers down right after its train, and a hit pixel powers down one cycle after its last entry is delivered.
- R10: A rising `fire_in` while `rec_en` is 0, or while storage power is off, records nothing and does not set overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| train_start | input | 1 | One-cycle pulse that opens a new bunch train |
| rec_en | input | 1 | High while the train is being recorded; low during readout |
| fire_in | input | 1 | Synchronised discriminator output |
| ts_bus | input | TS_W | Shared timestamp bus |
| rd_req | input | 1 | Read strobe, one entry per cycle |
| empty_o | output | 1 | No unread timestamp present |
| overflow_o | output | 1 | Sticky: a hit was dropped because every slot was full |
| mem_pwr_en | output | 1 | Storage power enable |
| rd_valid | output | 1 | `rd_data` holds an entry this cycle |
| rd_last | output | 1 | The delivered entry is the final unread one |
| rd_data | output | TS_W | Delivered timestamp |

## Verification
The bench builds the block with its defaults: a 14-bit timestamp and two slots. With only two slots, a handful of discriminator pulses per train is enough to reach the full and overflow state. Random fire patterns and random 14-bit bus values therefore exercise overflow, dropped hits and the order of readout in almost every train. Directed sequences cover the hit that arrives together with `train_start`, a held fire level, read strobes during recording, and the power-down of a pixel that recorded no hits.

// File: rtl/pixstamp_pkg.sv
package pixstamp_pkg;

  // True while a slot index still points inside the store.
  function automatic logic slot_free(input int unsigned wr_idx, input int unsigned depth);
    return wr_idx < depth;
  endfunction

  // True when the entry at rd_idx is the newest one written.
  function automatic logic final_entry(input int unsigned rd_idx, input int unsigned wr_idx);
    return (rd_idx + 1) == wr_idx;
  endfunction

endpackage

// File: rtl/pixstamp_edge.sv
module pixstamp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic rise_o
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_in;
  end

  assign rise_o = lvl_in & ~lvl_q;

endmodule

// File: rtl/pixstamp_slots.sv
module pixstamp_slots #(
  parameter int TS_W  = 14,
  parameter int DEPTH = 2,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [TS_W-1:0]  wr_data,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [TS_W-1:0]  rd_q,
  output logic [DEPTH-1:0] valid_o
);

  logic [DEPTH*TS_W-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [TS_W-1:0] q;
    logic            v;
    logic            sel;

    assign sel = wr_en && (wr_idx == PTR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
        v <= 1'b0;
      end else if (clr) begin
        v <= 1'b0;
      end else if (sel) begin
        q <= wr_data;
        v <= 1'b1;
      end
    end

    assign flat[g*TS_W +: TS_W] = q;
    assign valid_o[g]           = v;
  end

  always_comb begin
    rd_q = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == PTR_W'(i)) rd_q = flat[i*TS_W +: TS_W];
    end
  end

endmodule

// File: rtl/pixstamp_ctrl.sv
module pixstamp_ctrl #(
  parameter int TS_W  = 14,
  parameter int DEPTH = 2,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_start,
  input  logic             rec_en,
  input  logic             rd_req,
  input  logic             rise,
  input  logic [TS_W-1:0]  slot_q,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             wr_en,
  output logic             hit_ev,
  output logic             wr_full,
  output logic             empty,
  output logic             overflow,
  output logic             pwr_on,
  output logic             rd_valid,
  output logic             rd_last,
  output logic [TS_W-1:0]  rd_data
);

  logic rd_go;

  assign empty   = (rd_ptr == wr_ptr);
  assign wr_full = !pixstamp_pkg::slot_free(32'(wr_ptr), DEPTH);
  assign hit_ev  = rise & rec_en & pwr_on;
  assign wr_en   = hit_ev & ~wr_full & ~train_start;
  assign rd_go   = rd_req & ~rec_en & ~empty & ~train_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
      pwr_on   <= 1'b0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
    end else if (train_start) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
      pwr_on   <= 1'b1;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + PTR_W'(1);
      if (hit_ev && wr_full) overflow <= 1'b1;
      rd_valid <= rd_go;
      rd_last  <= rd_go && pixstamp_pkg::final_entry(32'(rd_ptr), 32'(wr_ptr));
      if (rd_go) begin
        rd_data <= slot_q;
        rd_ptr  <= rd_ptr + PTR_W'(1);
      end
      if (!rec_en && empty) pwr_on <= 1'b0;
    end
  end

endmodule

// File: rtl/pixstamp_recorder.sv
module pixstamp_recorder #(
  parameter int TS_W  = 14,
  parameter int DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            train_start,
  input  logic            rec_en,
  input  logic            fire_in,
  input  logic [TS_W-1:0] ts_bus,
  input  logic            rd_req,
  output logic            empty_o,
  output logic            overflow_o,
  output logic            mem_pwr_en,
  output logic            rd_valid,
  output logic            rd_last,
  output logic [TS_W-1:0] rd_data
);

  localparam int PTR_W = $clog2(DEPTH + 1);

  logic             fire_rise;
  logic             hit_ev;
  logic             wr_full;
  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [TS_W-1:0]  slot_q;
  logic [DEPTH-1:0] slot_valid;

  pixstamp_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (fire_in),
    .rise_o (fire_rise)
  );

  pixstamp_slots #(.TS_W(TS_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (train_start),
    .wr_en   (wr_en),
    .wr_idx  (wr_ptr),
    .wr_data (ts_bus),
    .rd_idx  (rd_ptr),
    .rd_q    (slot_q),
    .valid_o (slot_valid)
  );

  pixstamp_ctrl #(.TS_W(TS_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .train_start (train_start),
    .rec_en      (rec_en),
    .rd_req      (rd_req),
    .rise        (fire_rise),
    .slot_q      (slot_q),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .wr_en       (wr_en),
    .hit_ev      (hit_ev),
    .wr_full     (wr_full),
    .empty       (empty_o),
    .overflow    (overflow_o),
    .pwr_on      (mem_pwr_en),
    .rd_valid    (rd_valid),
    .rd_last     (rd_last),
    .rd_data     (rd_data)
  );

endmodule

// File: rtl/pixstamp_recorder_chk.sv
module pixstamp_recorder_chk #(
  parameter int DEPTH = 2,
  parameter int PTR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             train_start,
  input logic             rec_en,
  input logic             rd_req,
  input logic             empty_o,
  input logic             overflow_o,
  input logic             mem_pwr_en,
  input logic             rd_valid,
  input logic             rd_last,
  input logic             hit_ev,
  input logic             wr_full,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [DEPTH-1:0] slot_valid
);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    train_start |=> (empty_o && !overflow_o && mem_pwr_en && !rd_valid));

  assert_hit_stores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ev && !wr_full && !train_start) |=> !empty_o);

  assert_fill_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(slot_valid) == 32'(wr_ptr)) && (32'(wr_ptr) <= DEPTH));

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ev && wr_full && !train_start) |=> overflow_o);

  assert_no_overflow_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !train_start) |=> overflow_o);

  assert_read_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_req) && !$past(train_start)));

  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  assert_read_in_train_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(rec_en));

  assert_pwr_off_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pwr_en |-> empty_o);

  assert_pwr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_en && empty_o && !train_start) |=> !mem_pwr_en);

endmodule

bind pixstamp_recorder pixstamp_recorder_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .train_start (train_start),
  .rec_en      (rec_en),
  .rd_req      (rd_req),
  .empty_o     (empty_o),
  .overflow_o  (overflow_o),
  .mem_pwr_en  (mem_pwr_en),
  .rd_valid    (rd_valid),
  .rd_last     (rd_last),
  .hit_ev      (hit_ev),
  .wr_full     (wr_full),
  .wr_ptr      (wr_ptr),
  .slot_valid  (slot_valid)
);

// File: tb/pixstamp_recorder_test.sv
module pixstamp_recorder_test;

  localparam int TS_W  = 14;
  localparam int DEPTH = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            train_start = 1'b0;
  logic            rec_en = 1'b0;
  logic            fire_in = 1'b0;
  logic [TS_W-1:0] ts_bus = '0;
  logic            rd_req = 1'b0;
  logic            empty_o, overflow_o, mem_pwr_en, rd_valid, rd_last;
  logic [TS_W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pixstamp_recorder #(.TS_W(TS_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .rec_en(rec_en),
    .fire_in(fire_in), .ts_bus(ts_bus), .rd_req(rd_req),
    .empty_o(empty_o), .overflow_o(overflow_o), .mem_pwr_en(mem_pwr_en),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data)
  );

  // Reference state, kept from the requirements.
  logic [TS_W-1:0] m_slot [DEPTH];
  int              m_wr = 0, m_rd = 0;
  bit              m_ovf = 0, m_pwr = 0, m_fq = 0, m_rv = 0, m_rl = 0;
  logic [TS_W-1:0] m_rdata = '0;

  function automatic bit is_hit(bit fire, bit prev, bit rec, bit pwr);
    return fire && !prev && rec && pwr;
  endfunction

  function automatic bit is_final_read(int rd, int wr);
    return (wr - rd) == 1;
  endfunction

  task automatic model_step();
    bit empty_now = (m_rd == m_wr);
    bit h = is_hit(fire_in, m_fq, rec_en, m_pwr);
    if (train_start) begin
      m_wr = 0; m_rd = 0; m_ovf = 0; m_pwr = 1; m_rv = 0; m_rl = 0;
    end else begin
      if (h) begin
        if (m_wr < DEPTH) begin m_slot[m_wr] = ts_bus; m_wr++; end
        else m_ovf = 1;
      end
      if (rd_req && !rec_en && !empty_now) begin
        m_rv = 1; m_rl = is_final_read(m_rd, m_wr); m_rdata = m_slot[m_rd]; m_rd++;
      end else begin
        m_rv = 0; m_rl = 0;
      end
      if (!rec_en && empty_now) m_pwr = 0;
    end
    m_fq = fire_in;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(string ctx);
    bit exp_empty = (m_rd == m_wr);
    check(empty_o == exp_empty, {ctx, " R6 empty"}, empty_o, exp_empty);
    check(overflow_o == m_ovf, {ctx, " R5 overflow"}, overflow_o, m_ovf);
    check(mem_pwr_en == m_pwr, {ctx, " R9 power"}, mem_pwr_en, m_pwr);
    check(rd_valid == m_rv, {ctx, " R7 valid"}, rd_valid, m_rv);
    if (m_rv) begin
      check(rd_data == m_rdata, {ctx, " R4 data order"}, rd_data, m_rdata);
      check(rd_last == m_rl, {ctx, " R7 last"}, rd_last, m_rl);
    end
  endtask

  task automatic cyc(bit st, bit rec, bit fire, logic [TS_W-1:0] ts, bit rd, string ctx);
    train_start = st; rec_en = rec; fire_in = fire; ts_bus = ts; rd_req = rd;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R10: power off, rising fire with rec high records nothing
    cyc(0, 1, 0, 14'h0001, 0, "R10 pwr off");
    cyc(0, 1, 1, 14'h0002, 0, "R10 pwr off");

    // R2: start together with a rising fire; the hit is dropped
    cyc(0, 1, 0, 14'h0000, 0, "R2 prep");
    cyc(1, 1, 1, 14'h0AAA, 0, "R2 start priority");
    // R3: the held level gives no new hit
    cyc(0, 1, 1, 14'h0BBB, 0, "R3 held");
    cyc(0, 1, 1, 14'h0CCC, 0, "R3 held");
    cyc(0, 1, 0, 14'h0000, 0, "R3 fall");
    cyc(0, 1, 1, 14'h1ABC, 0, "R3 capture");
    cyc(0, 1, 0, 14'h0000, 1, "R8 read in train");
    cyc(0, 1, 1, 14'h0123, 0, "R4 second slot");
    cyc(0, 1, 0, 14'h0000, 0, "R5 prep");
    cyc(0, 1, 1, 14'h3FFF, 0, "R5 overflow");
    cyc(0, 0, 0, 14'h0000, 0, "R10 prep");
    cyc(0, 0, 1, 14'h2222, 0, "R10 rec low");
    cyc(0, 0, 0, 14'h0000, 1, "R4 oldest");
    cyc(0, 0, 0, 14'h0000, 1, "R7 last");
    cyc(0, 0, 0, 14'h0000, 1, "R7 none left");
    cyc(0, 0, 0, 14'h0000, 0, "R9 powered down");

    // R9: a pixel with no hits powers down right after its train
    cyc(1, 1, 0, 14'h0000, 0, "R9 start");
    cyc(0, 1, 0, 14'h0000, 0, "R9 train");
    cyc(0, 0, 0, 14'h0000, 0, "R9 train end");
    cyc(0, 0, 0, 14'h0000, 0, "R9 off");

    // Random trains
    for (int t = 0; t < 60; t++) begin
      cyc(1, 1, $urandom_range(0, 1), TS_W'($urandom), 0, "R2 rnd start");
      for (int c = 0; c < $urandom_range(8, 30); c++)
        cyc(0, 1, ($urandom_range(0, 99) < 40), TS_W'($urandom),
            ($urandom_range(0, 9) == 0), "R3 rnd record");
      for (int c = 0; c < $urandom_range(3, 10); c++)
        cyc(0, 0, $urandom_range(0, 1), TS_W'($urandom),
            ($urandom_range(0, 2) != 0), "R7 rnd read");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule